// File: doc/BRIEF.md
# Multi-Port PHY Event Interrupt Combiner

This block collects link-management events from every port of a multi-port Ethernet PHY and drives one shared, active-low interrupt line. Each port has five event sources: auto-negotiation done, link up/down change, speed change, duplex change and isolate change. Each source has a sticky pending bit, an enable bit and a per-port force-interrupt control.

A pending bit counts only when its enable is set. A port requests an interrupt when any of its enabled pending bits is set or when its force control is set. The requests of all ports are merged onto the single pin.

Software uses a small register port. It picks a port index and one of three registers: enable, pending status or force. Reading the status register returns the pending bits and clears them. An event that arrives in the same cycle as that read is kept, so it is never lost. Event detection and the management bus protocol are handled outside this block.

Top module: `phy_irq_agg`

## Requirements
- R1: After reset, all enable, status and force bits are zero, `irq_n` is high and `reg_rdata` is zero.
- R2: A one-cycle high on `evt_strobe[p*5+e]` sets status bit e of port p. The bit stays set until a status read of that port clears it. Bit 0 is auto-negotiation done, bit 1 speed change, bit 2 duplex change, bit 3 link change and bit 4 isolate change.
- R3: The `reg_sel` field selects the register: 0 is enable, 1 is status, 2 is force (bit 0 only) and 3 is none. When `reg_wr` is high, the enable register takes `reg_wdata` and the force register takes `reg_wdata[0]`.
- R4: Read data is registered. It appears on `reg_rdata` in the cycle after `reg_rd` and is held until the next read.
- R5: A status read returns the pending bits of the selected port and clears them.
- R6: If a strobe arrives in the same cycle as a clearing status read, the read returns the old bits and the new bit stays set afterwards.
- R7: Reading the enable or force register leaves all state unchanged.
- R8: `irq_n` is low exactly when some port has a status bit that is also enabled, or has its force bit set. It follows a strobe or a write at the same clock edge that updates the register.
- R9: A disabled event is still recorded in status but does not lower `irq_n`.
- R10: Writes to the status register or to select 3 are ignored. A port index of `NUM_PORTS` or more is ignored on writes and reads back zero.
- R11: The force bit holds `irq_n` low with no pending events, and clearing it releases the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | NUM_PORTS*5 | Event strobes, port p at bits p*5 to p*5+4 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_port | input | PORT_W | Port index |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 5 | Write data |
| reg_rdata | output | 5 | Registered read data |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
The main path is driven with several enable and event mask pairs across different ports. These pairs include full overlap, partial overlap, no overlap and a port with everything disabled. Together they separate the AND with the enable from the OR across events, and show that the status bits are recorded no matter what the enable is. Directed tests then cover:
- an event that lands in the same cycle as a clearing read;
- force with no pending events;
- requests from two ports merged on the pin;
- side-effect-free enable reads;
- writes aimed at status, at select 3 or at a port that does not exist.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
    localparam int unsigned NUM_EVT = 5;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_FORCE  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    typedef struct packed {
        evt_vec_t en;
        evt_vec_t st;
        logic     frc;
    } port_state_t;
endpackage

// File: rtl/phy_irq_port.sv
module phy_irq_port
    import phy_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t evt_i,
    input  logic     wr_en_i,
    input  logic     wr_frc_i,
    input  logic     rd_clr_i,
    input  evt_vec_t wdata_i,
    output evt_vec_t en_o,
    output evt_vec_t st_o,
    output logic     frc_o,
    output logic     irq_o
);
    port_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // a clearing read drops old bits, a new strobe always survives
        state_d.st = (rd_clr_i ? '0 : state_q.st) | evt_i;
        if (wr_en_i)  state_d.en  = wdata_i;
        if (wr_frc_i) state_d.frc = wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign en_o  = state_q.en;
    assign st_o  = state_q.st;
    assign frc_o = state_q.frc;
    assign irq_o = (|(state_q.st & state_q.en)) | state_q.frc;
endmodule

// File: rtl/phy_irq_rdmux.sv
module phy_irq_rdmux
    import phy_irq_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 8,
    parameter int unsigned PORT_W    = 4
) (
    input  logic [PORT_W-1:0]            port_i,
    input  reg_sel_e                     sel_i,
    input  logic [NUM_PORTS*NUM_EVT-1:0] en_all_i,
    input  logic [NUM_PORTS*NUM_EVT-1:0] st_all_i,
    input  logic [NUM_PORTS-1:0]         frc_all_i,
    output evt_vec_t                     data_o
);
    always_comb begin
        data_o = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_i == PORT_W'(p)) begin
                unique case (sel_i)
                    SEL_ENABLE: data_o = en_all_i[p*NUM_EVT +: NUM_EVT];
                    SEL_STATUS: data_o = st_all_i[p*NUM_EVT +: NUM_EVT];
                    SEL_FORCE:  data_o = {{(NUM_EVT-1){1'b0}}, frc_all_i[p]};
                    default:    data_o = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/phy_irq_merge.sv
module phy_irq_merge #(
    parameter int unsigned NUM_PORTS = 8
) (
    input  logic [NUM_PORTS-1:0] port_irq_i,
    output logic                 irq_n_o
);
    assign irq_n_o = ~(|port_irq_i);
endmodule

// File: rtl/phy_irq_agg.sv
module phy_irq_agg
    import phy_irq_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 8,
    parameter int unsigned PORT_W    = $clog2(NUM_PORTS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_PORTS*NUM_EVT-1:0] evt_strobe,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [PORT_W-1:0]            reg_port,
    input  logic [1:0]                   reg_sel,
    input  logic [NUM_EVT-1:0]           reg_wdata,
    output logic [NUM_EVT-1:0]           reg_rdata,
    output logic                         irq_n
);
    typedef struct packed {
        evt_vec_t rdata;
    } top_state_t;

    top_state_t top_d, top_q;

    reg_sel_e                     sel;
    logic [NUM_PORTS*NUM_EVT-1:0] en_all;
    logic [NUM_PORTS*NUM_EVT-1:0] st_all;
    logic [NUM_PORTS-1:0]         frc_all;
    logic [NUM_PORTS-1:0]         port_irq;
    evt_vec_t                     mux_data;

    assign sel = reg_sel_e'(reg_sel);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit = (reg_port == PORT_W'(p));

        phy_irq_port u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_strobe[p*NUM_EVT +: NUM_EVT]),
            .wr_en_i  (reg_wr && hit && sel == SEL_ENABLE),
            .wr_frc_i (reg_wr && hit && sel == SEL_FORCE),
            .rd_clr_i (reg_rd && hit && sel == SEL_STATUS),
            .wdata_i  (reg_wdata),
            .en_o     (en_all[p*NUM_EVT +: NUM_EVT]),
            .st_o     (st_all[p*NUM_EVT +: NUM_EVT]),
            .frc_o    (frc_all[p]),
            .irq_o    (port_irq[p])
        );
    end

    phy_irq_rdmux #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W)
    ) u_rdmux (
        .port_i    (reg_port),
        .sel_i     (sel),
        .en_all_i  (en_all),
        .st_all_i  (st_all),
        .frc_all_i (frc_all),
        .data_o    (mux_data)
    );

    phy_irq_merge #(
        .NUM_PORTS (NUM_PORTS)
    ) u_merge (
        .port_irq_i (port_irq),
        .irq_n_o    (irq_n)
    );

    always_comb begin
        top_d = top_q;
        if (reg_rd) top_d.rdata = mux_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign reg_rdata = top_q.rdata;
endmodule

// File: rtl/phy_irq_agg_chk.sv
module phy_irq_agg_chk
    import phy_irq_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 8,
    parameter int unsigned PORT_W    = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_PORTS*NUM_EVT-1:0] evt_strobe,
    input logic                         reg_rd,
    input logic [PORT_W-1:0]            reg_port,
    input logic [1:0]                   reg_sel,
    input logic [NUM_EVT-1:0]           reg_rdata,
    input logic                         irq_n,
    input logic [NUM_PORTS*NUM_EVT-1:0] en_all,
    input logic [NUM_PORTS*NUM_EVT-1:0] st_all,
    input logic [NUM_PORTS-1:0]         frc_all
);
    // R11
    force_holds_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|frc_all) |-> !irq_n);

    // R8
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((|(st_all & en_all)) || (|frc_all)));

    // R4
    rdata_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
            // R2 R6
            strobe_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
                evt_strobe[p*NUM_EVT+e] |=> st_all[p*NUM_EVT+e]);
        end

        // R5
        status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && reg_sel == 2'd1 && reg_port == PORT_W'(p)
             && evt_strobe[p*NUM_EVT +: NUM_EVT] == '0)
            |=> st_all[p*NUM_EVT +: NUM_EVT] == '0);

        // R5
        status_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && reg_sel == 2'd1 && reg_port == PORT_W'(p))
            |=> reg_rdata == $past(st_all[p*NUM_EVT +: NUM_EVT]));
    end
endmodule

bind phy_irq_agg phy_irq_agg_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_strobe (evt_strobe),
    .reg_rd     (reg_rd),
    .reg_port   (reg_port),
    .reg_sel    (reg_sel),
    .reg_rdata  (reg_rdata),
    .irq_n      (irq_n),
    .en_all     (en_all),
    .st_all     (st_all),
    .frc_all    (frc_all)
);

// File: tb/phy_irq_agg_tb.sv
module phy_irq_agg_tb;
    localparam int NP = 8;
    localparam int NE = 5;
    localparam int PW = 4;
    localparam int NV = 6;
    // {port[3:0], enable[4:0], events[4:0]}
    localparam logic [13:0] VEC [NV] = '{
        {4'd0, 5'b11111, 5'b00001},
        {4'd1, 5'b00010, 5'b00010},
        {4'd3, 5'b00100, 5'b01000},
        {4'd5, 5'b11000, 5'b11010},
        {4'd7, 5'b10000, 5'b10000},
        {4'd6, 5'b00000, 5'b11111}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP*NE-1:0]  evt_strobe = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [PW-1:0]     reg_port = '0;
    logic [1:0]        reg_sel = '0;
    logic [NE-1:0]     reg_wdata = '0;
    logic [NE-1:0]     reg_rdata;
    logic              irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [NE-1:0] rd;

    always #10 clk = ~clk;

    phy_irq_agg #(.NUM_PORTS(NP), .PORT_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_port(reg_port),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic check(string req, logic [NE-1:0] act, logic [NE-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(int port, int sel, logic [NE-1:0] data);
        reg_wr = 1'b1; reg_port = PW'(port); reg_sel = 2'(sel); reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(int port, int sel, output logic [NE-1:0] data);
        reg_rd = 1'b1; reg_port = PW'(port); reg_sel = 2'(sel);
        @(negedge clk);
        reg_rd = 1'b0;
        data = reg_rdata;
    endtask

    task automatic pulse(int port, logic [NE-1:0] mask);
        evt_strobe[port*NE +: NE] = mask;
        @(negedge clk);
        evt_strobe = '0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq_n", {4'b0, irq_n}, 5'b00001);
        check("R1 rdata", reg_rdata, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_reg(4, 0, rd); check("R1 enable", rd, 5'b0);
        rd_reg(4, 1, rd); check("R1 status", rd, 5'b0);
        rd_reg(4, 2, rd); check("R1 force", rd, 5'b0);

        // table walk: R2 R3 R5 R8 R9
        for (int i = 0; i < NV; i++) begin
            int p;
            logic [NE-1:0] en, ev;
            p = int'(VEC[i][13:10]); en = VEC[i][9:5]; ev = VEC[i][4:0];
            wr(p, 0, en);
            rd_reg(p, 0, rd); check("R3 enable readback", rd, en);
            pulse(p, ev);
            check("R8 R9 irq after event", {4'b0, irq_n}, {4'b0, ~(|(en & ev))});
            rd_reg(p, 1, rd); check("R2 R5 status value", rd, ev);
            check("R5 irq after clear", {4'b0, irq_n}, 5'b00001);
            rd_reg(p, 1, rd); check("R5 status cleared", rd, 5'b0);
            wr(p, 0, 5'b0);
        end

        // R6 strobe with clearing read
        pulse(2, 5'b01000);
        evt_strobe[2*NE +: NE] = 5'b00010;
        rd_reg(2, 1, rd);
        evt_strobe = '0;
        check("R6 read returns old", rd, 5'b01000);
        rd_reg(2, 1, rd); check("R6 new bit kept", rd, 5'b00010);

        // R7 enable/force reads leave state
        wr(4, 0, 5'b00001);
        pulse(4, 5'b00001);
        rd_reg(4, 0, rd); check("R7 enable read", rd, 5'b00001);
        rd_reg(4, 2, rd); check("R7 force read", rd, 5'b0);
        check("R7 irq kept", {4'b0, irq_n}, 5'b0);
        rd_reg(4, 1, rd); check("R7 status kept", rd, 5'b00001);

        // R10 ignored writes
        pulse(4, 5'b00100);
        wr(4, 1, 5'b00000);
        wr(4, 3, 5'b11111);
        wr(9, 0, 5'b11111);
        wr(9, 2, 5'b00001);
        check("R10 irq unaffected", {4'b0, irq_n}, 5'b00001);
        rd_reg(4, 1, rd); check("R10 status write ignored", rd, 5'b00100);
        rd_reg(4, 3, rd); check("R10 sel3 reads zero", rd, 5'b0);
        rd_reg(9, 0, rd); check("R10 bad port reads zero", rd, 5'b0);
        wr(4, 0, 5'b0);

        // R11 force
        wr(6, 2, 5'b00001);
        check("R11 force lowers irq", {4'b0, irq_n}, 5'b0);
        rd_reg(6, 2, rd); check("R3 force readback", rd, 5'b00001);
        wr(6, 2, 5'b00000);
        check("R11 release", {4'b0, irq_n}, 5'b00001);

        // R8 two ports merged, R4 hold
        wr(0, 0, 5'b00010); wr(7, 0, 5'b01000);
        pulse(0, 5'b00010); pulse(7, 5'b01000);
        rd_reg(0, 1, rd); check("R8 port0 pending", rd, 5'b00010);
        check("R8 port7 still holds irq", {4'b0, irq_n}, 5'b0);
        @(negedge clk);
        check("R4 rdata held", reg_rdata, 5'b00010);
        rd_reg(7, 1, rd); check("R8 port7 pending", rd, 5'b01000);
        check("R8 all clear", {4'b0, irq_n}, 5'b00001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule